// File: doc/BRIEF.md
# Oversampled Serial Receiver with Held Error Flags

This block takes an asynchronous serial line and turns each incoming character into a parallel word. The line is sampled by a clock that runs at sixteen times the bit rate. A start bit is found on a falling edge and checked again half a bit later. Each data bit, the optional parity bit and the first stop bit are then read at the middle of their bit periods. When the first stop bit has been read, the character goes into a holding register. Characters shorter than eight bits sit in the low bits of that register, and the unused high bits read as zero.

Four status flags report each character: data-ready, parity mismatch, framing fault and overrun. They do not pulse. Each flag keeps its value from one character to the next and changes only under its own rule. Software clears data-ready with an active-low strobe. The overrun flag clears only when a character completes after such a strobe. The frame format comes from static control inputs: 5 to 8 data bits, parity on or off, even or odd parity, and one or two stop bits. Two output-enable signals, one for the data word and one for the status flags, stand in for three-state control. A synchronous master reset clears all flags.

Top module: `uart_rx_flags`

## Requirements
- R1: Each received character is copied into the holding register once, when its first stop bit is sampled. Data bits arrive least significant first. Frame timing is 16 clock cycles per bit, and each bit is sampled at the middle of its period.
- R2: The data width is `word_len` + 5 bits (00 gives 5 bits, 11 gives 8 bits). The received bits are right-justified into `rx_data[0]` upward, and all bits above the word are zero.
- R3: `dr` goes high when a character is loaded. While `dr_clr_n` is low and no character is being loaded, `dr` falls to 0 on the next clock.
- R4: When parity is on, `pe` takes the mismatch result of each loaded character and holds it until the next character. Even parity (`parity_odd`=0) expects an even number of ones across the data bits and the parity bit, and odd parity expects an odd number. While `parity_en` is 0, `pe` is 0.
- R5: `fe` is set when the first stop bit of a character samples low. It holds until a character whose first stop bit samples high.
- R6: `ovr` is set when a character loads while `dr` is still high. It is cleared by the next character that loads after `dr` has been cleared.
- R7: A low on the line that is high again at the mid-bit check of the start bit is ignored. No character is loaded and no flag changes.
- R8: With `two_stop`=1, only the first stop bit is checked. A low level during the second stop bit neither sets `fe` nor starts a new character.
- R9: A high `rst` clears `dr`, `pe`, `fe` and `ovr` on the next clock.
- R10: `data_oe` is the registered inverse of `data_dis`, and `stat_oe` is the registered inverse of `stat_dis`. Each follows its input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16 times the bit rate |
| rst | input | 1 | Synchronous active-high master reset |
| rx_in | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present and checked |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| dr_clr_n | input | 1 | Active-low clear of data-ready |
| data_dis | input | 1 | Disable request for the data word |
| stat_dis | input | 1 | Disable request for the status flags |
| rx_data | output | 8 | Holding register, right-justified |
| data_oe | output | 1 | Output enable for rx_data |
| dr | output | 1 | Data ready |
| pe | output | 1 | Parity error |
| fe | output | 1 | Framing error |
| ovr | output | 1 | Overrun error |
| stat_oe | output | 1 | Output enable for the status flags |

## Verification
The bench sends a bad-parity character followed by a good one, and a bad-stop character followed by a good one. A design that pulsed its flags, or never cleared them, would show the wrong level after the second character of each pair.

Overrun is tested in three steps: two characters with no clear, then a third, then a clear followed by a character. A design that cleared the flag on the strobe itself, or kept it forever, would fail at one of these steps.

Other cases are:
- a five-bit word, which a design without right-justification would leave shifted up;
- a short glitch on the line, which a design without the mid-bit check would load as a character;
- a second stop bit held low, which a design that checked both stop bits would flag as a framing fault;
- clearing `parity_en` while `pe` is set, which a design that only updated the flag at load time would leave high.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_HOLD  = 3'd5
  } rx_state_t;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst ? 1'b1 : din;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= rst ? 1'b1 : chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxf_sampler.sv
module rxf_sampler
  import rxf_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 8,
  parameter int MIN_BITS   = 5,
  parameter int LEN_W      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                parity_en,
  input  logic                parity_odd,
  input  logic                two_stop,
  output logic                load,
  output logic [MAX_BITS-1:0] word,
  output logic                par_bad,
  output logic                stop_ok
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] TOP_CNT = CNT_W'(OVERSAMPLE - 1);

  rx_state_t           st;
  logic [CNT_W-1:0]    cnt;
  logic [BIT_W-1:0]    bit_i;
  logic [BIT_W-1:0]    nbits;
  logic [BIT_W-1:0]    shamt;
  logic [MAX_BITS-1:0] shreg;
  logic                par_acc;
  logic                line_prev;

  assign nbits = BIT_W'(MIN_BITS) + BIT_W'(word_len);
  assign shamt = BIT_W'(MAX_BITS) - nbits;

  always_ff @(posedge clk) begin
    if (rst) line_prev <= 1'b1;
    else     line_prev <= line;
  end

  always_ff @(posedge clk) begin
    load <= 1'b0;
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_i   <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      word    <= '0;
      par_bad <= 1'b0;
      stop_ok <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (line_prev && !line) st <= S_START;
        end
        S_START: begin
          if (cnt == MID_CNT) begin
            cnt     <= '0;
            bit_i   <= '0;
            par_acc <= 1'b0;
            st      <= line ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == TOP_CNT) begin
            cnt     <= '0;
            shreg   <= {line, shreg[MAX_BITS-1:1]};
            par_acc <= par_acc ^ line;
            bit_i   <= bit_i + 1'b1;
            if (bit_i == nbits - 1'b1) st <= parity_en ? S_PAR : S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt == TOP_CNT) begin
            cnt     <= '0;
            par_bad <= par_acc ^ line ^ parity_odd;
            st      <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == TOP_CNT) begin
            cnt     <= '0;
            stop_ok <= line;
            word    <= shreg >> shamt;
            load    <= 1'b1;
            if (!parity_en) par_bad <= 1'b0;
            st      <= two_stop ? S_HOLD : S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == TOP_CNT) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

  // R7
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && cnt == MID_CNT && line) |=> (st == S_IDLE));
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] word,
  input  logic                par_bad,
  input  logic                stop_ok,
  input  logic                parity_en,
  input  logic                dr_clr_n,
  output logic [MAX_BITS-1:0] hold,
  output logic                dr,
  output logic                pe,
  output logic                fe,
  output logic                ovr
);
  logic dr_live;
  assign dr_live = dr & dr_clr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      dr   <= 1'b0;
      fe   <= 1'b0;
      ovr  <= 1'b0;
    end else if (load) begin
      hold <= word;
      dr   <= 1'b1;
      fe   <= !stop_ok;
      ovr  <= dr_live;
    end else if (!dr_clr_n) begin
      dr   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !parity_en) pe <= 1'b0;
    else if (load)         pe <= par_bad;
  end

  // R3
  dr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!dr_clr_n && !load) |=> !dr);

  // R4
  pe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !parity_en |=> !pe);

  // R5
  fe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(fe));

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (load && dr && dr_clr_n) |=> ovr);

  // R6
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !dr) |=> !ovr);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int OVERSAMPLE  = 16,
  parameter int MAX_BITS    = 8,
  parameter int MIN_BITS    = 5,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_in,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                parity_en,
  input  logic                parity_odd,
  input  logic                two_stop,
  input  logic                dr_clr_n,
  input  logic                data_dis,
  input  logic                stat_dis,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                data_oe,
  output logic                dr,
  output logic                pe,
  output logic                fe,
  output logic                ovr,
  output logic                stat_oe
);
  logic                line;
  logic                load;
  logic [MAX_BITS-1:0] word;
  logic                par_bad;
  logic                stop_ok;

  rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(line)
  );

  rxf_sampler #(
    .OVERSAMPLE(OVERSAMPLE), .MAX_BITS(MAX_BITS),
    .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
  ) u_sampler (
    .clk(clk), .rst(rst), .line(line),
    .word_len(word_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop),
    .load(load), .word(word), .par_bad(par_bad), .stop_ok(stop_ok)
  );

  rxf_flags #(.MAX_BITS(MAX_BITS)) u_flags (
    .clk(clk), .rst(rst), .load(load), .word(word),
    .par_bad(par_bad), .stop_ok(stop_ok), .parity_en(parity_en),
    .dr_clr_n(dr_clr_n), .hold(rx_data), .dr(dr), .pe(pe),
    .fe(fe), .ovr(ovr)
  );

  always_ff @(posedge clk) begin
    data_oe <= !data_dis;
    stat_oe <= !stat_dis;
  end

  // R10
  data_oe_chk: assert property (@(posedge clk) disable iff (rst)
    data_dis |=> !data_oe);

  // R10
  stat_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_dis |=> stat_oe);
endmodule

// File: tb/uart_rx_flags_bench.sv
module uart_rx_flags_bench;
  localparam int OS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       dr_clr_n = 1'b1;
  logic       data_dis = 1'b0;
  logic       stat_dis = 1'b0;
  logic [7:0] rx_data;
  logic       data_oe, dr, pe, fe, ovr, stat_oe;

  always #10 clk = ~clk;

  uart_rx_flags u_uart_rx_flags (
    .clk(clk), .rst(rst), .rx_in(rx_in), .word_len(word_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .dr_clr_n(dr_clr_n), .data_dis(data_dis), .stat_dis(stat_dis),
    .rx_data(rx_data), .data_oe(data_oe), .dr(dr), .pe(pe), .fe(fe),
    .ovr(ovr), .stat_oe(stat_oe)
  );

  typedef struct {
    logic [7:0] data;
    logic       pe, fe, ovr, dr;
    string      req;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic exp_dr = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " data"}, 32'(rx_data), 32'(e.data));
      check({e.req, " dr"},   32'(dr),      32'(e.dr));
      check({e.req, " pe"},   32'(pe),      32'(e.pe));
      check({e.req, " fe"},   32'(fe),      32'(e.fe));
      check({e.req, " ovr"},  32'(ovr),     32'(e.ovr));
    end
  end

  task automatic hold_bit(input logic v);
    rx_in = v;
    repeat (OS) @(negedge clk);
  endtask

  task automatic send(input string req, input logic [7:0] d, input int len,
                      input bit pen, input bit podd, input bit two,
                      input bit bad_par, input bit bad_stop, input bit stop2);
    logic [7:0] m;
    logic p;
    exp_t e;
    m = d & 8'((1 << len) - 1);
    word_len = 2'(len - 5);
    parity_en = pen; parity_odd = podd; two_stop = two;
    p = (^m) ^ podd ^ bad_par;
    hold_bit(1'b0);
    for (int i = 0; i < len; i++) hold_bit(m[i]);
    if (pen) hold_bit(p);
    hold_bit(!bad_stop);
    if (two) hold_bit(stop2);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    e.data = m;
    e.pe   = pen & bad_par;
    e.fe   = bad_stop;
    e.ovr  = exp_dr;
    e.dr   = 1'b1;
    e.req  = req;
    exp_dr = 1'b1;
    q.push_back(e);
    ->chk_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_dr();
    dr_clr_n = 1'b0;
    @(negedge clk);
    dr_clr_n = 1'b1;
    exp_dr = 1'b0;
    @(negedge clk);
    check("R3 dr cleared", 32'(dr), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 reset dr", 32'(dr), 32'd0);
    check("R9 reset flags", 32'({pe, fe, ovr}), 32'd0);
    check("R10 enables after reset", 32'({data_oe, stat_oe}), 32'h3);

    send("R1 8N1", 8'hA5, 8, 0, 0, 0, 0, 0, 1);
    clear_dr();
    send("R2 five-bit", 8'hF5, 5, 0, 0, 0, 0, 0, 1);
    clear_dr();
    send("R2 seven-bit", 8'h3C, 7, 0, 0, 0, 0, 0, 1);
    clear_dr();
    send("R4 even good", 8'h37, 8, 1, 0, 0, 0, 0, 1);
    clear_dr();
    send("R4 even bad", 8'h37, 8, 1, 0, 0, 1, 0, 1);
    clear_dr();
    send("R4 odd good", 8'h12, 6, 1, 1, 0, 0, 0, 1);
    clear_dr();
    send("R4 odd bad", 8'h12, 6, 1, 1, 0, 1, 0, 1);
    parity_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 pe forced low", 32'(pe), 32'd0);
    clear_dr();
    send("R5 bad stop", 8'h5A, 8, 0, 0, 0, 0, 1, 1);
    clear_dr();
    send("R5 stop ok", 8'h66, 8, 0, 0, 0, 0, 0, 1);
    send("R6 overrun set", 8'h01, 8, 0, 0, 0, 0, 0, 1);
    send("R6 overrun held", 8'h02, 8, 0, 0, 0, 0, 0, 1);
    clear_dr();
    check("R6 ovr kept by strobe", 32'(ovr), 32'd1);
    send("R6 overrun cleared", 8'h03, 8, 0, 0, 0, 0, 0, 1);
    clear_dr();
    // R7 false start glitch
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * OS) @(negedge clk);
    check("R7 glitch no dr", 32'(dr), 32'd0);
    check("R7 glitch data kept", 32'(rx_data), 32'h03);
    // R8 low second stop ignored
    send("R8 two stop", 8'h9C, 8, 0, 0, 1, 0, 0, 0);
    clear_dr();
    repeat (3 * OS) @(negedge clk);
    check("R8 no spurious char", 32'(dr), 32'd0);
    // R10 output enables
    data_dis = 1'b1;
    @(negedge clk);
    check("R10 data_oe low", 32'(data_oe), 32'd0);
    stat_dis = 1'b1;
    data_dis = 1'b0;
    @(negedge clk);
    check("R10 stat_oe low", 32'(stat_oe), 32'd0);
    check("R10 data_oe back", 32'(data_oe), 32'd1);
    stat_dis = 1'b0;
    @(negedge clk);
    check("R10 stat_oe back", 32'(stat_oe), 32'd1);
    // R9 master reset clears set flags
    send("R9 setup", 8'h44, 8, 1, 0, 0, 1, 1, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_dr = 1'b0;
    check("R9 mr dr", 32'(dr), 32'd0);
    check("R9 mr flags", 32'({pe, fe, ovr}), 32'd0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule